// File: doc/BRIEF.md
# GPIO Pad Controller with Event Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pads. Each pad owns one 32-bit configuration word. Software uses that word to set the level driven onto the pad and to read back the synchronised level coming in from it. The same word chooses how the incoming level becomes an interrupt event. The input may first be inverted, and the event can then follow the level, a rising edge, both edges, or nothing at all.

Each pad's events are latched into a status bit. Status bits are grouped 32 pads to a word and are cleared by writing ones. A matching bank of enable words gates the status into a single interrupt line. Enables do not stop latching, so a status bit can be polled while its interrupt is masked.

Software reaches the block through a plain write strobe, an address and write data. Read data follows the address combinationally, and reads have no side effects.

Top module: `gpioc_top`

## Requirements
- R1: The configuration word of pad n is at byte address 0x600 + 16*n. Field positions in that word: output level at bit 0, input level at bit 1, input inversion at bit 23, event mode at bits 26:25. Only these bits hold state. All other bits of the word, and the other three words of each 16-byte slot, read as zero.
- R2: Bit 0 of pad n's configuration word drives `pad_out[n]`, starting from the clock edge that accepts the write. The bit reads back as written.
- R3: Bit 1 reads the pad input after two synchroniser flops. A change on `pad_in[n]` shows up in bit 1 after the second rising clock edge. Writes to bit 1 have no effect.
- R4: When bit 23 is set, the synchronised input is inverted before event detection. Events are then generated on the low level or on the falling edge.
- R5: Event mode 00 is level mode. The status bit is set on every cycle in which the (possibly inverted) input is 1. A write-one clear therefore leaves the bit at 1 while that level persists.
- R6: Event mode 01 sets the status bit only when the (possibly inverted) input goes from 0 to 1. It does so once per transition.
- R7: Event mode 11 sets the status bit on every change of the synchronised input, in either direction.
- R8: Event mode 10 never sets the status bit.
- R9: Status word b is at 0x100 + 4*b and holds pad 32*b + i at bit i. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R10: Enable word b is at 0x110 + 4*b, with the same bit mapping. It is fully writable and readable, and reset clears every enable bit.
- R11: `irq` is 1 exactly when some pad has both its status bit and its enable bit set. A status bit latches whatever its enable bit is.
- R12: Reset sets every configuration word to output 0, no inversion and mode 00, and clears every status bit. Status and enable bits above the last pad read as zero, as do whole words beyond the last bank and any address outside the three regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Output levels driven onto the pads |
| irq | output | 1 | OR of status AND enable over all pads |

## Verification
Pads are driven with slow single-bit transitions while every event mode is set up in turn, with and without inversion. This shows that rising-edge, both-edge, level and disabled modes react differently to the same rise-then-fall sequence. Write-one clears are issued while a level-mode input is still active and again after it has gone away, which separates re-arming by level from one-shot edge latching. A seeded random phase then mixes pad toggles, configuration rewrites with junk in the unused bits, status clears and enable writes across all banks. After every step, every status, enable and configuration word is compared against a bench model, which also exposes any mapping error at bank boundaries and at the last pad.

// File: rtl/gpioc_pkg.sv
package gpioc_pkg;

    localparam int unsigned STAT_BASE  = 32'h100;
    localparam int unsigned EN_BASE    = 32'h110;
    localparam int unsigned CFG_BASE   = 32'h600;
    localparam int unsigned CFG_STRIDE = 16;
    localparam int unsigned BANK_BITS  = 32;
    localparam int unsigned MAX_BANKS  = 4;

    localparam int unsigned TX_BIT  = 0;
    localparam int unsigned RX_BIT  = 1;
    localparam int unsigned INV_BIT = 23;
    localparam int unsigned MODE_LO = 25;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'b00,
        EV_RISE  = 2'b01,
        EV_NONE  = 2'b10,
        EV_BOTH  = 2'b11
    } ev_mode_t;

    typedef struct packed {
        logic     tx;
        logic     inv;
        ev_mode_t mode;
    } pad_cfg_t;

    function automatic logic [31:0] cfg_word(pad_cfg_t c, logic rx);
        logic [31:0] w;
        w = '0;
        w[TX_BIT]        = c.tx;
        w[RX_BIT]        = rx;
        w[INV_BIT]       = c.inv;
        w[MODE_LO +: 2]  = c.mode;
        return w;
    endfunction

    function automatic logic event_hit(ev_mode_t m, logic now, logic prev);
        case (m)
            EV_LEVEL: return now;
            EV_RISE:  return now & ~prev;
            EV_BOTH:  return now ^ prev;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpioc_sync.sv
module gpioc_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpioc_pad_cell.sv
module gpioc_pad_cell
    import gpioc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_sync,
    input  logic     cfg_we,
    input  pad_cfg_t cfg_d,
    input  logic     st_clr,
    output pad_cfg_t cfg_q,
    output logic     st_q
);
    logic rx_d_q;
    logic s_now;
    logic s_prev;
    logic ev;

    // inversion applied to both samples so toggling it never fakes an edge
    assign s_now  = rx_sync ^ cfg_q.inv;
    assign s_prev = rx_d_q  ^ cfg_q.inv;
    assign ev     = event_hit(cfg_q.mode, s_now, s_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{tx: 1'b0, inv: 1'b0, mode: EV_LEVEL};
            rx_d_q <= 1'b0;
            st_q   <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= cfg_d;
            rx_d_q <= rx_sync;
            st_q   <= (st_q & ~st_clr) | ev;
        end
    end

    assert_level_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == EV_LEVEL && (rx_sync ^ cfg_q.inv)) |=> st_q);

    assert_rise_needs_change_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == EV_RISE && !st_q && rx_sync == rx_d_q) |=> !st_q);

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == EV_NONE && !st_q) |=> !st_q);

    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q.tx));
endmodule

// File: rtl/gpioc_top.sv
module gpioc_top
    import gpioc_pkg::*;
#(
    parameter int unsigned NUM_PADS = 80,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic                irq
);
    localparam int unsigned NUM_BANKS = (NUM_PADS + BANK_BITS - 1) / BANK_BITS;
    localparam int unsigned WIDE      = MAX_BANKS * BANK_BITS;
    localparam int unsigned IDX_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

    logic [NUM_PADS-1:0] rx_sync;
    logic [NUM_PADS-1:0] cfg_we;
    logic [NUM_PADS-1:0] st_clr;
    logic [NUM_PADS-1:0] st_vec;
    logic [NUM_PADS-1:0] en_q;
    pad_cfg_t            cfg_arr [NUM_PADS];
    pad_cfg_t            cfg_d;

    assign cfg_d = '{tx:   bus_wdata[TX_BIT],
                     inv:  bus_wdata[INV_BIT],
                     mode: ev_mode_t'(bus_wdata[MODE_LO +: 2])};

    gpioc_sync #(.WIDTH(NUM_PADS)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (rx_sync)
    );

    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
        localparam int unsigned BANK = k / BANK_BITS;
        localparam int unsigned BIT  = k % BANK_BITS;
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_BASE + k * CFG_STRIDE);
        localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(STAT_BASE + 4 * BANK);
        localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_BASE + 4 * BANK);

        assign cfg_we[k] = bus_wr && (bus_addr == A_CFG);
        assign st_clr[k] = bus_wr && (bus_addr == A_ST) && bus_wdata[BIT];

        always_ff @(posedge clk) begin
            if (rst)                              en_q[k] <= 1'b0;
            else if (bus_wr && bus_addr == A_EN)  en_q[k] <= bus_wdata[BIT];
        end

        gpioc_pad_cell cell_i (
            .clk     (clk),
            .rst     (rst),
            .rx_sync (rx_sync[k]),
            .cfg_we  (cfg_we[k]),
            .cfg_d   (cfg_d),
            .st_clr  (st_clr[k]),
            .cfg_q   (cfg_arr[k]),
            .st_q    (st_vec[k])
        );

        assign pad_out[k] = cfg_arr[k].tx;
    end

    assign irq = |(st_vec & en_q);

    // read path
    logic [WIDE-1:0]   st_wide;
    logic [WIDE-1:0]   en_wide;
    logic [ADDR_W-1:0] cfg_off;
    logic              cfg_hit;
    logic              st_hit;
    logic              en_hit;
    logic [IDX_W-1:0]  pad_idx;
    logic [1:0]        bank_sel;

    assign st_wide  = WIDE'(st_vec);
    assign en_wide  = WIDE'(en_q);
    assign cfg_off  = bus_addr - ADDR_W'(CFG_BASE);
    assign pad_idx  = cfg_off[IDX_W+3:4];
    assign bank_sel = bus_addr[3:2];
    assign cfg_hit  = (bus_addr >= ADDR_W'(CFG_BASE)) && (cfg_off[3:0] == 4'd0)
                   && (cfg_off[ADDR_W-1:4] < (ADDR_W-4)'(NUM_PADS));
    assign st_hit   = (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(STAT_BASE >> 4))
                   && (bus_addr[1:0] == 2'd0);
    assign en_hit   = (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(EN_BASE >> 4))
                   && (bus_addr[1:0] == 2'd0);

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit)     bus_rdata = cfg_word(cfg_arr[pad_idx], rx_sync[pad_idx]);
        else if (st_hit) bus_rdata = st_wide[bank_sel * BANK_BITS +: BANK_BITS];
        else if (en_hit) bus_rdata = en_wide[bank_sel * BANK_BITS +: BANK_BITS];
    end

    initial begin
        assert (NUM_BANKS <= MAX_BANKS);
        assert (CFG_BASE + NUM_PADS * CFG_STRIDE <= (1 << ADDR_W));
    end

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|en_q));

    assert_enable_write_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(EN_BASE)) |=> (en_q[0] == $past(bus_wdata[0])));
endmodule

// File: tb/gpioc_top_tb_top.sv
module gpioc_top_tb_top;
    localparam int N  = 80;
    localparam int AW = 12;
    localparam int NB = (N + 31) / 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic          irq;

    always #5 clk = ~clk;

    gpioc_top #(.NUM_PADS(N), .ADDR_W(AW)) dut_i (
        .clk, .rst, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .pad_in, .pad_out, .irq
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    bit       m_tx [N];
    bit       m_inv[N];
    bit [1:0] m_mode[N];
    bit       m_st [N];
    bit       m_en [N];
    bit       pins [N];

    function automatic bit ev_of(bit [1:0] mode, bit inv, bit oldp, bit newp);
        bit o = oldp ^ inv;
        bit s = newp ^ inv;
        case (mode)
            2'b00: return s;
            2'b01: return !o && s;
            2'b11: return o != s;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_cfg(int k);
        logic [31:0] w = '0;
        w[0] = m_tx[k]; w[1] = pins[k]; w[23] = m_inv[k]; w[26:25] = m_mode[k];
        return w;
    endfunction

    function automatic logic [31:0] exp_bank(int b, bit use_en);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++)
            if (b * 32 + i < N) w[i] = use_en ? m_en[b*32+i] : m_st[b*32+i];
        return w;
    endfunction

    function automatic bit exp_irq();
        for (int k = 0; k < N; k++) if (m_st[k] && m_en[k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic relevel();
        for (int k = 0; k < N; k++)
            if (m_mode[k] == 2'b00 && (pins[k] ^ m_inv[k])) m_st[k] = 1'b1;
    endtask

    task automatic set_cfg(int k, bit tx, bit inv, bit [1:0] mode, logic [31:0] junk);
        logic [31:0] w = junk & 32'hF97F_FFFC;
        w[0] = tx; w[1] = junk[0]; w[23] = inv; w[26:25] = mode;
        wr(AW'(32'h600 + 16 * k), w);
        m_tx[k] = tx; m_inv[k] = inv; m_mode[k] = mode;
        @(negedge clk);
        relevel();
    endtask

    task automatic set_pin(int k, bit v);
        bit old = pins[k];
        @(negedge clk);
        pad_in[k] = v;
        repeat (4) @(negedge clk);
        pins[k] = v;
        if (ev_of(m_mode[k], m_inv[k], old, v)) m_st[k] = 1'b1;
    endtask

    task automatic clr_stat(int b, logic [31:0] mask);
        wr(AW'(32'h100 + 4 * b), mask);
        for (int i = 0; i < 32; i++)
            if (b * 32 + i < N && mask[i]) m_st[b*32+i] = 1'b0;
        relevel();
    endtask

    task automatic set_en(int b, logic [31:0] mask);
        wr(AW'(32'h110 + 4 * b), mask);
        for (int i = 0; i < 32; i++)
            if (b * 32 + i < N) m_en[b*32+i] = mask[i];
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin
            rd(AW'(32'h100 + 4 * b), d); chk(tag, "status word", d, exp_bank(b, 0));
            rd(AW'(32'h110 + 4 * b), d); chk(tag, "enable word", d, exp_bank(b, 1));
        end
        for (int k = 0; k < N; k++) begin
            rd(AW'(32'h600 + 16 * k), d); chk(tag, "config word", d, exp_cfg(k));
            chk(tag, "pad_out bit", 32'(pad_out[k]), 32'(m_tx[k]));
        end
        chk(tag, "irq", 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int k = 0; k < N; k++) begin
            m_tx[k] = 0; m_inv[k] = 0; m_mode[k] = 0; m_st[k] = 0; m_en[k] = 0; pins[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R12 reset state and R10 enables clear
        check_all("R12");
        check_all("R10");
        // R12 unmapped locations
        rd(AW'(12'h608), d); chk("R12", "slot word 2", d, 0);
        rd(AW'(12'hB00), d); chk("R12", "cfg past last pad", d, 0);
        rd(AW'(12'h10C), d); chk("R12", "status bank 3", d, 0);
        rd(AW'(12'h11C), d); chk("R12", "enable bank 3", d, 0);
        rd(AW'(12'h200), d); chk("R12", "hole", d, 0);

        // R3 two-flop latency on pad 5
        @(negedge clk);
        bus_addr = AW'(32'h600 + 16 * 5);
        pad_in[5] = 1'b1;
        @(posedge clk); #1 chk("R3", "rx after 1 edge", 32'(bus_rdata[1]), 0);
        @(posedge clk); #1 chk("R3", "rx after 2 edges", 32'(bus_rdata[1]), 1);
        repeat (3) @(negedge clk);
        pins[5] = 1'b1; m_st[5] = 1'b1;
        check_all("R3");

        // R1 R2 config readback with junk, rx bit not writable
        set_cfg(7, 1, 0, 2'b10, 32'hFFFF_FFFF);
        check_all("R1");
        check_all("R2");

        // R6 rising edge only
        set_cfg(40, 0, 0, 2'b01, 32'h0);
        set_pin(40, 1); check_all("R6");
        clr_stat(1, 32'h0000_0100); check_all("R9");
        set_pin(40, 0); check_all("R6");

        // R7 both edges
        set_cfg(41, 0, 0, 2'b11, 32'h0);
        set_pin(41, 1); clr_stat(1, 32'h0000_0200);
        set_pin(41, 0); check_all("R7");

        // R8 disabled mode
        set_cfg(42, 0, 0, 2'b10, 32'h0);
        set_pin(42, 1); set_pin(42, 0); check_all("R8");

        // R4 inverted level, R5 clear while active
        set_cfg(43, 0, 1, 2'b00, 32'h0); check_all("R4");
        clr_stat(1, 32'h0000_0800); check_all("R5");
        set_pin(43, 1); clr_stat(1, 32'h0000_0800); check_all("R5");
        clr_stat(0, 32'h0); check_all("R9");

        // R11 masked latch, then enable
        check_all("R11");
        set_en(1, 32'h0000_0200); check_all("R11");
        set_en(2, 32'hFFFF_FFFF); check_all("R10");

        // last pad, inverted falling edge
        set_cfg(N - 1, 1, 1, 2'b01, 32'h0);
        set_pin(N - 1, 1); set_pin(N - 1, 0); check_all("R4");

        // seeded random mix
        for (int it = 0; it < 120; it++) begin
            int op = $urandom_range(0, 3);
            int k  = $urandom_range(0, N - 1);
            case (op)
                0: set_pin(k, !pins[k]);
                1: set_cfg(k, 1'($urandom), 1'($urandom), 2'($urandom), $urandom);
                2: clr_stat($urandom_range(0, NB - 1), $urandom);
                default: set_en($urandom_range(0, NB - 1), $urandom);
            endcase
            check_all("R4");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule